// File: doc/BRIEF.md
# Dual-FIFO Character Port

The block connects a processor bus to a host byte stream through two independent character queues of 64 entries each. The processor sees two 32-bit registers. The data register pops received characters and pushes characters to send. The control register holds the interrupt enables, the pending flags and the free transmit space. On the host side there is a valid/ready byte stream in each direction. The receive stream fills the receive queue, and the transmit stream drains the transmit queue in order.

Two level-sensitive interrupt conditions are derived from the queue fill levels. The read condition is raised when the receive queue is nearly full, or when characters are waiting and the host has stopped sending for a set number of cycles. The write condition is raised when the transmit queue is nearly empty. The thresholds and the idle window are elaboration-time parameters. A single interrupt output combines both pending flags.

Bus accesses are single-cycle. Read data is combinational from the current state. A data-register read pops at the end of the access cycle.

Top module: `char_port`

## Requirements
- R1: After reset, the receive queue is empty and the transmit queue is empty. The control register reads 64 in bits 31:16 with all other bits 0. `irq_o` and `tx_valid_o` are low, and `rx_ready_o` is high.
- R2: A read with `sel_i`=0 (data register) while the receive queue holds N>0 characters returns the following, then pops one entry. Bits 7:0 hold the oldest character. Bit 15 (RVALID) is 1. Bits 31:16 hold N-1, the count left after this pop. A host push in the same cycle is not included in that count. Characters come out in arrival order.
- R3: A data read while the receive queue is empty returns 0 in all bits. It leaves the queue unchanged.
- R4: A write with `sel_i`=0 pushes `wdata_i[7:0]` into the transmit queue, and bits 31:8 are ignored. `tx_valid_o` is high while the queue is non-empty, and `tx_data_o` shows the oldest character. The character is removed on a cycle with both `tx_valid_o` and `tx_ready_i` high.
- R5: A data write while the transmit queue holds 64 characters is discarded. The queue contents and the free count are unchanged.
- R6: A read with `sel_i`=1 (control register) returns the following bits. Bits 31:16 hold the free transmit entries. Bit 0 is the read-interrupt enable and bit 1 is the write-interrupt enable. Both enables are written from `wdata_i[1:0]` by a control write.
- R7: Control bit 8 (read pending) is 1 when bit 0 is set and the receive queue has RTV (default 8) or fewer free entries.
- R8: Control bit 8 is also 1 when bit 0 is set, the receive queue is non-empty, and no host character has been accepted for IDLE_CYCLES (default 32) cycles.
- R9: Control bit 9 (write pending) is 1 when bit 1 is set and the transmit queue holds WTV (default 8) or fewer characters.
- R10: `irq_o` is high exactly when control bit 8 or bit 9 is 1. With both enables clear, it stays low.
- R11: `rx_ready_o` is low while the receive queue holds 64 characters, and host bytes offered then are dropped. A host push and a processor pop in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe, one cycle per access |
| wr_i | input | 1 | 1 = write, 0 = read |
| sel_i | input | 1 | Register select: 0 data, 1 control |
| wdata_i | input | 32 | Bus write data |
| rdata_o | output | 32 | Bus read data, valid in the access cycle |
| rx_valid_i | input | 1 | Host offers a receive byte |
| rx_data_i | input | 8 | Host receive byte |
| rx_ready_o | output | 1 | Receive queue can accept |
| tx_valid_o | output | 1 | Transmit byte available |
| tx_data_o | output | 8 | Oldest transmit byte |
| tx_ready_i | input | 1 | Host takes the transmit byte |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The host push and the processor pop can hit the receive queue in the same cycle. A transmit write and a host drain can likewise coincide on the transmit queue. The bench holds `rx_valid_i` high during a data-register read. It checks that the returned count excludes the incoming byte, and that later reads return both the remaining and the new characters in order with the correct counts. A queue filled to 64 is used to check that a push with ready low is dropped rather than overwriting data.

// File: rtl/char_port_pkg.sv
package char_port_pkg;
  typedef enum logic {SEL_DATA = 1'b0, SEL_CTRL = 1'b1} reg_sel_e;
  localparam int RVALID_BIT = 15;
  localparam int RE_BIT     = 0;
  localparam int WE_BIT     = 1;
  localparam int RI_BIT     = 8;
  localparam int WI_BIT     = 9;
endpackage

// File: rtl/char_fifo.sv
module char_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  data_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem_q[rd_ptr_q];
  assign count_o = cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= nxt(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= nxt(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= data_i;
  end
endmodule

// File: rtl/idle_timer.sv
module idle_timer #(
  parameter int CYCLES = 32,
  localparam int TW    = $clog2(CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic activity_i,
  output logic idle_o
);
  logic [TW-1:0] cnt_q;

  assign idle_o = (cnt_q == TW'(CYCLES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (activity_i) cnt_q <= '0;
    else if (!idle_o)    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/char_port.sv
module char_port
  import char_port_pkg::*;
#(
  parameter int DEPTH       = 64,
  parameter int RTV         = 8,
  parameter int WTV         = 8,
  parameter int IDLE_CYCLES = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        wr_i,
  input  logic        sel_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_data_i,
  output logic        rx_ready_o,
  output logic        tx_valid_o,
  output logic [7:0]  tx_data_o,
  input  logic        tx_ready_i,
  output logic        irq_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] rx_cnt, tx_cnt, rx_free;
  logic          rx_full, rx_empty, tx_full, tx_empty;
  logic [7:0]    rx_head;
  logic          rx_push, rx_pop, tx_push, tx_pop;
  logic          host_idle, re_q, we_q, rd_cond, wr_cond, ri, wi;
  logic [15:0]   ravail, wspace;
  logic          unused_wdata;

  assign unused_wdata = ^wdata_i[31:8];

  assign rx_push = rx_valid_i && !rx_full;
  assign rx_pop  = req_i && !wr_i && (sel_i == SEL_DATA);
  assign tx_push = req_i && wr_i && (sel_i == SEL_DATA);
  assign tx_pop  = tx_ready_i && !tx_empty;

  char_fifo #(.DEPTH(DEPTH), .W(8)) u_rx_fifo (
    .clk_i, .rst_ni,
    .push_i (rx_push), .data_i (rx_data_i),
    .pop_i  (rx_pop),  .data_o (rx_head),
    .count_o(rx_cnt),  .full_o (rx_full), .empty_o(rx_empty)
  );

  char_fifo #(.DEPTH(DEPTH), .W(8)) u_tx_fifo (
    .clk_i, .rst_ni,
    .push_i (tx_push), .data_i (wdata_i[7:0]),
    .pop_i  (tx_pop),  .data_o (tx_data_o),
    .count_o(tx_cnt),  .full_o (tx_full), .empty_o(tx_empty)
  );

  idle_timer #(.CYCLES(IDLE_CYCLES)) u_idle (
    .clk_i, .rst_ni, .activity_i(rx_push), .idle_o(host_idle)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      re_q <= 1'b0;
      we_q <= 1'b0;
    end else if (req_i && wr_i && (sel_i == SEL_CTRL)) begin
      re_q <= wdata_i[RE_BIT];
      we_q <= wdata_i[WE_BIT];
    end
  end

  assign rx_free = CW'(DEPTH) - rx_cnt;
  assign rd_cond = !rx_empty && ((rx_free <= CW'(RTV)) || host_idle);
  assign wr_cond = (tx_cnt <= CW'(WTV));
  assign ri      = re_q && rd_cond;
  assign wi      = we_q && wr_cond;
  assign irq_o   = ri || wi;

  assign ravail     = rx_empty ? 16'd0 : 16'(rx_cnt) - 16'd1;
  assign wspace     = 16'(CW'(DEPTH) - tx_cnt);
  assign rx_ready_o = !rx_full;
  assign tx_valid_o = !tx_empty;

  always_comb begin
    rdata_o = '0;
    if (sel_i == SEL_CTRL) begin
      rdata_o[31:16]  = wspace;
      rdata_o[RE_BIT] = re_q;
      rdata_o[WE_BIT] = we_q;
      rdata_o[RI_BIT] = ri;
      rdata_o[WI_BIT] = wi;
    end else if (!rx_empty) begin
      rdata_o[31:16]      = ravail;
      rdata_o[RVALID_BIT] = 1'b1;
      rdata_o[7:0]        = rx_head;
    end
  end
endmodule

// File: rtl/char_port_chk.sv
module char_port_chk #(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          wr_i,
  input logic          sel_i,
  input logic          rx_valid_i,
  input logic          rx_ready_o,
  input logic          tx_valid_o,
  input logic [7:0]    tx_data_o,
  input logic          tx_ready_i,
  input logic          irq_o,
  input logic          re_q,
  input logic          we_q,
  input logic [CW-1:0] rx_cnt,
  input logic [CW-1:0] tx_cnt
);
  logic data_rd, data_wr, host_push;
  assign data_rd   = req_i && !wr_i && !sel_i;
  assign data_wr   = req_i && wr_i && !sel_i;
  assign host_push = rx_valid_i && rx_ready_o;

  p_rx_full_block_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_cnt == CW'(DEPTH)) |-> !rx_ready_o);

  p_pop_one_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd && rx_cnt != '0 && !host_push) |=> (rx_cnt == $past(rx_cnt) - 1'b1));

  p_empty_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd && rx_cnt == '0 && !host_push) |=> (rx_cnt == '0));

  p_tx_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr && tx_cnt == CW'(DEPTH) && !tx_ready_i) |=> $stable(tx_cnt));

  p_tx_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));

  p_irq_enable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (re_q || we_q));

  p_tx_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_cnt <= CW'(DEPTH));
endmodule

bind char_port char_port_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i, .rst_ni, .req_i, .wr_i, .sel_i, .rx_valid_i, .rx_ready_o,
  .tx_valid_o, .tx_data_o, .tx_ready_i, .irq_o,
  .re_q(re_q), .we_q(we_q), .rx_cnt(rx_cnt), .tx_cnt(tx_cnt)
);

// File: tb/char_port_tb_top.sv
module char_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, wr = 1'b0, sel = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic        rx_valid = 1'b0, rx_ready;
  logic [7:0]  rx_data = '0, tx_data;
  logic        tx_valid, tx_ready = 1'b0, irq;
  int          n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  char_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .wr_i(wr), .sel_i(sel),
    .wdata_i(wdata), .rdata_o(rdata), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .rx_ready_o(rx_ready), .tx_valid_o(tx_valid), .tx_data_o(tx_data),
    .tx_ready_i(tx_ready), .irq_o(irq)
  );

  task automatic chk(input string req_id, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req_id, act, exp);
    end
  endtask

  task automatic bus_rd(input logic s, output logic [31:0] d);
    @(negedge clk); req = 1; wr = 0; sel = s;
    #5 d = rdata;
    @(negedge clk); req = 0;
  endtask

  task automatic bus_wr(input logic s, input logic [31:0] d);
    @(negedge clk); req = 1; wr = 1; sel = s; wdata = d;
    @(negedge clk); req = 0; wr = 0;
  endtask

  task automatic host_push(input logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_data = b;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    #1;
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 tx_valid", {31'd0, tx_valid}, 32'd0);
    chk("R1 rx_ready", {31'd0, rx_ready}, 32'd1);
    bus_rd(1'b1, d); chk("R1 ctrl", d, 32'h0040_0000);
    bus_rd(1'b0, d); chk("R1 data", d, 32'd0);
  endtask

  task automatic t_rx_basic;
    logic [31:0] d;
    host_push(8'hA1); host_push(8'hB2); host_push(8'hC3);
    bus_rd(1'b0, d); chk("R2 first", d, 32'h0002_80A1);
    bus_rd(1'b0, d); chk("R2 second", d, 32'h0001_80B2);
    bus_rd(1'b0, d); chk("R2 third", d, 32'h0000_80C3);
    bus_rd(1'b0, d); chk("R3 empty read", d, 32'd0);
    host_push(8'h5A);
    bus_rd(1'b0, d); chk("R3 no effect", d, 32'h0000_805A);
  endtask

  task automatic t_tx_basic;
    logic [31:0] d;
    tx_ready = 0;
    bus_wr(1'b0, 32'hFFFF_FF11); bus_wr(1'b0, 32'h1234_5622); bus_wr(1'b0, 32'h0000_0033);
    bus_rd(1'b1, d); chk("R6 wspace 61", d, 32'h003D_0000);
    chk("R4 tx_valid", {31'd0, tx_valid}, 32'd1);
    chk("R4 head", {24'd0, tx_data}, 32'h11);
    tx_ready = 1;
    @(negedge clk); chk("R4 order 2", {24'd0, tx_data}, 32'h22);
    @(negedge clk); chk("R4 order 3", {24'd0, tx_data}, 32'h33);
    @(negedge clk); chk("R4 drained", {31'd0, tx_valid}, 32'd0);
    tx_ready = 0;
  endtask

  task automatic t_tx_full;
    logic [31:0] d;
    tx_ready = 0;
    for (int i = 0; i < 66; i++) bus_wr(1'b0, 32'(i));
    bus_rd(1'b1, d); chk("R5 wspace 0", d, 32'h0000_0000);
    tx_ready = 1;
    for (int i = 0; i < 64; i++) begin
      #1 chk("R5 kept", {24'd0, tx_data}, 32'(i));
      @(negedge clk);
    end
    chk("R5 extras dropped", {31'd0, tx_valid}, 32'd0);
    tx_ready = 0;
  endtask

  task automatic t_write_irq;
    logic [31:0] d;
    bus_wr(1'b1, 32'h0000_0002);
    bus_rd(1'b1, d); chk("R9 empty pending", d, 32'h0040_0202);
    chk("R10 irq from WI", {31'd0, irq}, 32'd1);
    for (int i = 0; i < 8; i++) bus_wr(1'b0, 32'h40 + 32'(i));
    bus_rd(1'b1, d); chk("R9 eight pending", d, 32'h0038_0202);
    bus_wr(1'b0, 32'h48);
    bus_rd(1'b1, d); chk("R9 nine clear", d, 32'h0037_0002);
    chk("R10 irq low", {31'd0, irq}, 32'd0);
    bus_wr(1'b1, 32'h0000_0003);
    bus_rd(1'b1, d); chk("R6 enables", d & 32'h3, 32'h3);
    tx_ready = 1; idle(12); tx_ready = 0;
    bus_wr(1'b1, 32'h0);
  endtask

  task automatic t_read_threshold;
    logic [31:0] d;
    bus_wr(1'b1, 32'h1);
    for (int i = 0; i < 55; i++) host_push(8'(i));
    bus_rd(1'b1, d); chk("R7 55 no RI", d & 32'h300, 32'h0);
    chk("R10 irq low 55", {31'd0, irq}, 32'd0);
    host_push(8'd55);
    bus_rd(1'b1, d); chk("R7 56 RI", d & 32'h300, 32'h100);
    chk("R10 irq high 56", {31'd0, irq}, 32'd1);
    bus_rd(1'b0, d); chk("R2 head 0", d, 32'h0037_8000);
    bus_rd(1'b1, d); chk("R7 read down", d & 32'h300, 32'h0);
    for (int i = 1; i < 56; i++) bus_rd(1'b0, d);
    chk("R2 last", d, 32'h0000_8037);
  endtask

  task automatic t_idle;
    logic [31:0] d;
    host_push(8'h77);
    idle(5);
    bus_rd(1'b1, d); chk("R8 not idle yet", d & 32'h300, 32'h0);
    idle(40);
    bus_rd(1'b1, d); chk("R8 idle RI", d & 32'h300, 32'h100);
    chk("R10 irq idle", {31'd0, irq}, 32'd1);
    bus_rd(1'b0, d); chk("R8 char", d, 32'h0000_8077);
    chk("R8 cleared", {31'd0, irq}, 32'd0);
    bus_wr(1'b1, 32'h0);
    host_push(8'h78); idle(40);
    chk("R10 disabled", {31'd0, irq}, 32'd0);
    bus_rd(1'b1, d); chk("R10 no RI", d & 32'h300, 32'h0);
    bus_rd(1'b0, d);
  endtask

  task automatic t_concurrent;
    logic [31:0] d;
    host_push(8'h01); host_push(8'h02);
    @(negedge clk); req = 1; wr = 0; sel = 0; rx_valid = 1; rx_data = 8'h03;
    #5 d = rdata;
    @(negedge clk); req = 0; rx_valid = 0;
    chk("R11 concurrent pop", d, 32'h0001_8001);
    bus_rd(1'b0, d); chk("R11 after 2", d, 32'h0001_8002);
    bus_rd(1'b0, d); chk("R11 after 3", d, 32'h0000_8003);
    for (int i = 0; i < 64; i++) host_push(8'(i + 100));
    #1 chk("R11 full ready", {31'd0, rx_ready}, 32'd0);
    host_push(8'hFF);
    for (int i = 0; i < 64; i++) begin
      bus_rd(1'b0, d);
      chk("R11 content", d, {16'(63 - i), 8'h80, 8'(i + 100)});
    end
    bus_rd(1'b0, d); chk("R11 dropped", d, 32'd0);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    idle(2); rst_n = 1;
    t_reset();
    t_rx_basic();
    t_tx_basic();
    t_tx_full();
    t_write_irq();
    t_read_threshold();
    t_idle();
    t_concurrent();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule